// File: doc/BRIEF.md
# Two-Step Timestamp Queue

This block collects the hardware timestamps that a two-step precision time protocol flow needs and holds them in first-in first-out order until the CPU reads them. An upstream classifier raises an event strobe with the port number and a kind flag. The current nanosecond and sub-nanosecond time arrive as inputs. A receive event stores one entry. A transmit event stores two entries in the same cycle. The first is the transmit stamp. The second follows it, is not flagged as transmit, and carries the frame identifier split across its stamp fields.

The CPU side sees the head entry and its status on plain output ports. It pops an entry with a one-cycle next strobe. An interrupt follows the not-empty state. A sticky overflow flag records any event that had to be dropped for lack of room, and a write-one-to-clear strobe clears it. Seconds are not stored. Software forms them from a separate time snapshot and subtracts one when the snapshot's nanoseconds are below the stored nanoseconds.

Top module: `tstamp_queue`

## Requirements
- R1: After reset, headValid, headOvf and irq are all 0.
- R2: A receive event (evtValid=1, evtIsTx=0) stores one entry with headTx=0, headPort=evtPort, headNsec=curNsec and headSubns=curSubns. If the queue was empty, this entry is visible at the head one clock edge after the event is sampled.
- R3: An event is dropped when the room before that edge is too small. A transmit event needs 2 free slots and a receive event needs 1; a pop in the same cycle does not add room. A dropped event stores nothing and sets headOvf. headOvf stays 1 until it is cleared.
- R4: ovfClear=1 clears headOvf on the next edge. If a drop happens in the same cycle, headOvf stays 1.
- R5: A transmit event stores two consecutive entries. The first has headTx=1 with curNsec, curSubns and evtPort. The second has headTx=0 and the same port, with headSubns=evtFrameId[7:0] and headNsec=evtFrameId>>8, zero-extended. The frame identifier is 9 bits wide (0 to 511).
- R6: popNext=1 removes the head entry, so the following entry is visible after the edge. popNext on an empty queue has no effect.
- R7: Entries leave in the order they were stored, and the queue holds up to 32 entries.
- R8: irq equals headValid, and headValid is 1 exactly when the queue holds at least one entry.
- R9: An accepted push and a pop in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| curNsec | input | 30 | Current time, nanoseconds |
| curSubns | input | 8 | Current time, sub-nanoseconds |
| evtValid | input | 1 | Timestamp event strobe |
| evtIsTx | input | 1 | 1: two-step transmit event, 0: receive event |
| evtPort | input | 7 | Port number of the event |
| evtFrameId | input | 9 | Frame identifier for a transmit event |
| popNext | input | 1 | Pop the head entry |
| ovfClear | input | 1 | Write-one-to-clear for the overflow flag |
| headValid | output | 1 | Queue not empty |
| headOvf | output | 1 | Sticky overflow flag |
| headTx | output | 1 | Head entry is a transmit stamp |
| headPort | output | 7 | Head entry port |
| headNsec | output | 30 | Head entry nanoseconds |
| headSubns | output | 8 | Head entry sub-nanoseconds |
| irq | output | 1 | Interrupt, raised while entries wait |

## Verification
Each event, pop, or clear is sampled on one rising edge, and its effect is due at the outputs right after that same edge. The head read is combinational from the storage, so a push into an empty queue, a pop, and a change of the overflow flag all show up one edge after the stimulus. The bench changes inputs on the falling edge, lets exactly one rising edge pass, and compares the outputs on the next falling edge. A scoreboard queue holds the entries the bench expects, in order, and each head entry is compared with the front of that queue before it is popped.

// File: rtl/tsq_pkg.sv
package tsq_pkg;
  parameter int NSEC_W  = 30;
  parameter int SUBNS_W = 8;
  parameter int PORT_W  = 7;
  parameter int ID_W    = 9;

  // One queue entry; validity is tracked by the occupancy count.
  typedef struct packed {
    logic              isTx;
    logic [PORT_W-1:0] port;
    logic [NSEC_W-1:0] nsec;
    logic [SUBNS_W-1:0] subns;
  } stampT;

  // Strobes from control to datapath.
  typedef struct packed {
    logic wrFirst;  // write entry at the write pointer
    logic wrPair;   // also write the identifier entry behind it
    logic rdPop;    // advance the read pointer
  } strobeT;
endpackage

// File: rtl/tsq_ctrl.sv
module tsq_ctrl
  import tsq_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   evtValid,
  input  logic   evtIsTx,
  input  logic   popNext,
  input  logic   ovfClear,
  output strobeT strb,
  output logic   notEmpty,
  output logic   ovf
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] freeSlots;
  logic             fits;
  logic             drop;

  always_comb begin
    freeSlots    = CNT_W'(DEPTH) - count;
    // Room is judged before any same-cycle pop.
    fits         = evtIsTx ? (freeSlots >= CNT_W'(2)) : (freeSlots != '0);
    drop         = evtValid && !fits;
    strb.wrFirst = evtValid && fits;
    strb.wrPair  = evtValid && evtIsTx && fits;
    strb.rdPop   = popNext && (count != '0);
    notEmpty     = (count != '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
      ovf   <= 1'b0;
    end else begin
      count <= count + CNT_W'(strb.wrFirst) + CNT_W'(strb.wrPair)
                     - CNT_W'(strb.rdPop);
      if (drop)          ovf <= 1'b1;
      else if (ovfClear) ovf <= 1'b0;
    end
  end
endmodule

// File: rtl/tsq_data.sv
module tsq_data
  import tsq_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobeT             strb,
  input  logic               evtIsTx,
  input  logic [PORT_W-1:0]  evtPort,
  input  logic [ID_W-1:0]    evtFrameId,
  input  logic [NSEC_W-1:0]  curNsec,
  input  logic [SUBNS_W-1:0] curSubns,
  output stampT              head
);
  // DEPTH must be a power of two so the pointers wrap on their own.
  localparam int PTR_W = $clog2(DEPTH);
  localparam int ID_HI = ID_W - SUBNS_W;

  stampT            store [DEPTH];
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;
  logic [PTR_W-1:0] wrNext;
  stampT            stampEnt;
  stampT            idEnt;

  always_comb begin
    wrNext         = wrPtr + PTR_W'(1);
    stampEnt.isTx  = evtIsTx;
    stampEnt.port  = evtPort;
    stampEnt.nsec  = curNsec;
    stampEnt.subns = curSubns;
    idEnt.isTx     = 1'b0;
    idEnt.port     = evtPort;
    idEnt.nsec     = NSEC_W'(evtFrameId[ID_W-1 -: ID_HI]);
    idEnt.subns    = evtFrameId[SUBNS_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (strb.wrFirst) store[wrPtr]  <= stampEnt;
    if (strb.wrPair)  store[wrNext] <= idEnt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      wrPtr <= wrPtr + PTR_W'(strb.wrFirst) + PTR_W'(strb.wrPair);
      if (strb.rdPop) rdPtr <= rdPtr + PTR_W'(1);
    end
  end

  assign head = store[rdPtr];
endmodule

// File: rtl/tstamp_queue.sv
module tstamp_queue
  import tsq_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NSEC_W-1:0]  curNsec,
  input  logic [SUBNS_W-1:0] curSubns,
  input  logic               evtValid,
  input  logic               evtIsTx,
  input  logic [PORT_W-1:0]  evtPort,
  input  logic [ID_W-1:0]    evtFrameId,
  input  logic               popNext,
  input  logic               ovfClear,
  output logic               headValid,
  output logic               headOvf,
  output logic               headTx,
  output logic [PORT_W-1:0]  headPort,
  output logic [NSEC_W-1:0]  headNsec,
  output logic [SUBNS_W-1:0] headSubns,
  output logic               irq
);
  strobeT strb;
  stampT  head;
  logic   notEmpty;

  tsq_ctrl #(.DEPTH(DEPTH)) ctrl (
    .clk(clk), .rstN(rstN), .evtValid(evtValid), .evtIsTx(evtIsTx),
    .popNext(popNext), .ovfClear(ovfClear), .strb(strb),
    .notEmpty(notEmpty), .ovf(headOvf)
  );

  tsq_data #(.DEPTH(DEPTH)) data (
    .clk(clk), .rstN(rstN), .strb(strb), .evtIsTx(evtIsTx),
    .evtPort(evtPort), .evtFrameId(evtFrameId), .curNsec(curNsec),
    .curSubns(curSubns), .head(head)
  );

  assign headValid = notEmpty;
  assign irq       = notEmpty;
  assign headTx    = head.isTx;
  assign headPort  = head.port;
  assign headNsec  = head.nsec;
  assign headSubns = head.subns;
endmodule

// File: rtl/tstamp_queue_chk.sv
module tstamp_queue_chk (
  input logic clk,
  input logic rstN,
  input logic evtValid,
  input logic evtIsTx,
  input logic popNext,
  input logic ovfClear,
  input logic headValid,
  input logic headOvf,
  input logic headTx
);
  assert_ovf_sticky_R3: assert property (@(posedge clk) disable iff (!rstN)
    (headOvf && !ovfClear) |=> headOvf);

  assert_ovf_clear_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ovfClear && !evtValid) |=> !headOvf);

  assert_empty_stays_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!headValid && !evtValid) |=> !headValid);

  assert_rx_push_R2: assert property (@(posedge clk) disable iff (!rstN)
    (evtValid && !evtIsTx && !headValid) |=> (headValid && !headTx));

  assert_pair_head_R5: assert property (@(posedge clk) disable iff (!rstN)
    (evtValid && evtIsTx && !headValid) |=> (headValid && headTx));

  assert_pop_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    (popNext && headValid && !evtValid && !headTx) |=> $stable(headOvf) || ovfClear);
endmodule

bind tstamp_queue tstamp_queue_chk chk (
  .clk(clk), .rstN(rstN), .evtValid(evtValid), .evtIsTx(evtIsTx),
  .popNext(popNext), .ovfClear(ovfClear), .headValid(headValid),
  .headOvf(headOvf), .headTx(headTx)
);

// File: tb/tstamp_queue_test.sv
`timescale 1ns/1ps
module tstamp_queue_test;
  import tsq_pkg::*;
  localparam int DEPTH = 32;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic               rstN;
  logic [NSEC_W-1:0]  curNsec;
  logic [SUBNS_W-1:0] curSubns;
  logic               evtValid, evtIsTx, popNext, ovfClear;
  logic [PORT_W-1:0]  evtPort;
  logic [ID_W-1:0]    evtFrameId;
  logic               headValid, headOvf, headTx, irq;
  logic [PORT_W-1:0]  headPort;
  logic [NSEC_W-1:0]  headNsec;
  logic [SUBNS_W-1:0] headSubns;

  tstamp_queue #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rstN(rstN), .curNsec(curNsec), .curSubns(curSubns),
    .evtValid(evtValid), .evtIsTx(evtIsTx), .evtPort(evtPort),
    .evtFrameId(evtFrameId), .popNext(popNext), .ovfClear(ovfClear),
    .headValid(headValid), .headOvf(headOvf), .headTx(headTx),
    .headPort(headPort), .headNsec(headNsec), .headSubns(headSubns),
    .irq(irq)
  );

  stampT expQ[$];
  int    checks = 0;
  int    fails  = 0;
  bit    done   = 0;

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Model: accept into the scoreboard if room, per R3/R5.
  function automatic void modelPush(bit isTx, int port, int id, int ns, int sub);
    stampT a, b;
    int free = DEPTH - expQ.size();
    if ((isTx && free >= 2) || (!isTx && free >= 1)) begin
      a.isTx = isTx; a.port = PORT_W'(port); a.nsec = NSEC_W'(ns); a.subns = SUBNS_W'(sub);
      expQ.push_back(a);
      if (isTx) begin
        b.isTx = 1'b0; b.port = PORT_W'(port);
        b.nsec = NSEC_W'(id >> 8); b.subns = SUBNS_W'(id & 255);
        expQ.push_back(b);
      end
    end
  endfunction

  task automatic driveEvt(bit isTx, int port, int id, int ns, int sub);
    evtValid = 1'b1; evtIsTx = isTx; evtPort = PORT_W'(port);
    evtFrameId = ID_W'(id); curNsec = NSEC_W'(ns); curSubns = SUBNS_W'(sub);
  endtask

  // Driver: one event, one edge.
  task automatic sendEvent(bit isTx, int port, int id, int ns, int sub);
    driveEvt(isTx, port, id, ns, sub);
    modelPush(isTx, port, id, ns, sub);
    @(negedge clk);
    evtValid = 1'b0;
  endtask

  // Monitor: compare head with scoreboard front, then pop it.
  task automatic popCheck(string tag);
    stampT got;
    check({tag, " headValid"}, 64'(headValid), 64'(1));
    if (expQ.size() != 0) begin
      got = {headTx, headPort, headNsec, headSubns};
      check({tag, " entry"}, 64'(got), 64'(expQ[0]));
      void'(expQ.pop_front());
    end
    popNext = 1'b1;
    @(negedge clk);
    popNext = 1'b0;
  endtask

  task automatic drainAll(string tag);
    while (expQ.size() != 0) popCheck(tag);
    check({tag, " empty after drain"}, 64'(headValid), 64'(0));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; evtValid = 1'b0; evtIsTx = 1'b0; evtPort = '0; evtFrameId = '0;
    curNsec = '0; curSubns = '0; popNext = 1'b0; ovfClear = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 headValid", 64'(headValid), 64'(0));
    check("R1 headOvf", 64'(headOvf), 64'(0));
    check("R1 irq", 64'(irq), 64'(0));
    rstN = 1'b1;
    @(negedge clk);

    // R2 single receive entry
    sendEvent(0, 3, 0, 1234, 'h5A);
    check("R8 irq with entry", 64'(irq), 64'(1));
    popCheck("R2");
    check("R6 empty after pop", 64'(headValid), 64'(0));
    check("R8 irq when empty", 64'(irq), 64'(0));

    // R5 transmit pairs, identifiers at the ends and middle
    sendEvent(1, 5, 'h1A5, 777, 'h11);
    popCheck("R5 stamp");
    popCheck("R5 id");
    sendEvent(1, 9, 511, 99999, 'hFE);
    sendEvent(1, 10, 0, 5, 0);
    drainAll("R5 wrap ids");

    // R6 pop on empty ignored
    popNext = 1'b1; @(negedge clk); popNext = 1'b0;
    check("R6 pop empty", 64'(headValid), 64'(0));
    sendEvent(0, 7, 0, 42, 3);
    popCheck("R6 after empty pop");

    // R7 mixed order
    sendEvent(0, 1, 0, 100, 1);
    sendEvent(1, 2, 300, 200, 2);
    sendEvent(0, 4, 0, 300, 4);
    drainAll("R7 order");

    // R9 simultaneous push and pop
    sendEvent(0, 11, 0, 1000, 9);
    driveEvt(0, 12, 0, 2000, 8);
    modelPush(0, 12, 0, 2000, 8);
    popNext = 1'b1;
    void'(expQ.pop_front());
    @(negedge clk);
    evtValid = 1'b0; popNext = 1'b0;
    drainAll("R9");

    // R3 fill to depth, one more drops
    for (int i = 0; i < DEPTH; i++) sendEvent(0, i, 0, 5000 + i, i);
    check("R3 no ovf at full", 64'(headOvf), 64'(0));
    sendEvent(0, 99, 0, 1, 1);
    check("R3 ovf on drop", 64'(headOvf), 64'(1));
    drainAll("R7 depth");
    check("R3 ovf sticky", 64'(headOvf), 64'(1));
    ovfClear = 1'b1; @(negedge clk); ovfClear = 1'b0;
    check("R4 ovf cleared", 64'(headOvf), 64'(0));

    // R3 pair needs two slots
    for (int i = 0; i < DEPTH - 1; i++) sendEvent(0, i, 0, i, 0);
    sendEvent(1, 20, 77, 123, 4);
    check("R3 pair dropped", 64'(headOvf), 64'(1));
    ovfClear = 1'b1; @(negedge clk); ovfClear = 1'b0;
    sendEvent(0, 21, 0, 321, 6);
    check("R3 rx fits last slot", 64'(headOvf), 64'(0));
    // R4 drop beats clear in the same cycle
    ovfClear = 1'b1;
    sendEvent(0, 22, 0, 1, 1);
    ovfClear = 1'b0;
    check("R4 drop wins over clear", 64'(headOvf), 64'(1));
    drainAll("R7 refill");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule